// File: doc/BRIEF.md
# Output Fault Retry and Latch Controller

This block decides when the main and standby output stages of a power converter may run. Fault detectors elsewhere raise flags for each rail. This block turns those flags into two enable gates, a latched-off status and a count of restart attempts. All of its timing is paced by a one-cycle millisecond tick.

A main-rail fault switches off only the main rail. The block then waits a fixed retry interval and restarts the rail. It does this a bounded number of times, and the next fault after that leaves the main rail latched off. An unbroken stretch of healthy running clears the attempt count. Static overcurrent on the main rail is blanked, so it only counts as a fault once it has lasted longer than the blanking window. An overvoltage on either rail latches the whole supply off at once, with no retry.

Standby overcurrent starts a hiccup cycle. The standby rail goes off, which also removes the main rail, and the block tries again after a fixed off time for as long as the overload lasts. Removing input power, or turning the active-low enable pin off and then on again, clears every latch and the attempt count.

Top module: `fault_retry_ctrl`

## Requirements
- R1: After reset `retry_cnt` is 0, `latched` is 0 and `main_en` is 0. `sby_en` equals `in_ok` whenever no overvoltage latch or hiccup is active.
- R2: If `main_uv` or `main_sense` is high at a clock edge while `main_en` is high, `main_en` is low after that edge and `retry_cnt` has risen by one. `sby_en` does not change.
- R3: After a main fault that did not latch, `main_en` comes back once RETRY_MS ticks have been counted, and not before.
- R4: A main fault that arrives while `retry_cnt` equals MAX_RETRY sets `latched` and holds `main_en` low. The count stays at MAX_RETRY, `sby_en` stays high, and the state holds until a clear.
- R5: A clear resets `latched` and `retry_cnt` to 0. A clear is `in_ok` low at a clock edge, or a high-then-low transition of `on_n` as seen after its synchroniser.
- R6: When `main_en` has stayed high with no fault for CLEAR_MS ticks, `retry_cnt` returns to 0.
- R7: `main_oc` trips the main rail only on the (BLANK_MS+1)th tick it has been held high continuously while `main_en` is high. It then behaves as an R2 fault. A shorter pulse has no effect.
- R8: `ov_flag` high with `in_ok` high drops both `main_en` and `sby_en` and sets `latched` at the next edge. `retry_cnt` does not change, and no restart follows.
- R9: `sby_oc` while `sby_en` is high drops `sby_en` and `main_en` at the next edge. `sby_en` returns after HICCUP_MS ticks, and the cycle repeats while the overload persists.
- R10: `main_en` goes high only when `on_n` has been low for two clock edges (synchroniser depth), `in_ok` is high, and no latch, wait or hiccup is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| in_ok | input | 1 | Input power present |
| on_n | input | 1 | Active-low enable pin, asynchronous |
| main_oc | input | 1 | Main rail current above static limit |
| main_uv | input | 1 | Main rail undervoltage |
| main_sense | input | 1 | Main rail sense-line fault |
| ov_flag | input | 1 | Overvoltage on either rail |
| sby_oc | input | 1 | Standby rail overcurrent |
| main_en | output | 1 | Main rail enable gate |
| sby_en | output | 1 | Standby rail enable gate |
| latched | output | 1 | Supply is latched off |
| retry_cnt | output | $clog2(MAX_RETRY+1) | Restart attempts used |

## Verification
The bench aims at the sixth main fault. A design with an off-by-one there would either restart a sixth time or latch after only five faults. It holds the overcurrent flag for one tick short of the blanking window and then past it, which exposes a blanking counter that trips early or never trips at all. It also drives a long healthy run to check that the attempt count clears, and it checks that an enable toggle or loss of input clears a latch. Finally, it holds a standby overload so that the hiccup has to repeat, and it checks that a standby fault also removes the main rail while a main fault leaves standby running.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [1:0] {M_RUN = 2'd0, M_WAIT = 2'd1, M_LATCH = 2'd2} mstate_t;

  function automatic int cnt_bits(input int limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  function automatic logic attempts_used(input int cnt, input int max_retry);
    return cnt >= max_retry;
  endfunction
endpackage

// File: rtl/fr_pin_sync.sv
module fr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fell
);
  localparam int N = STAGES + 1;
  logic [N-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[N-2:0], pin};
  end

  assign level = q[STAGES-1];
  assign fell  = q[STAGES] & ~q[STAGES-1];
endmodule

// File: rtl/fr_tick_timer.sv
module fr_tick_timer #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic hit
);
  localparam int W = fr_pkg::cnt_bits(LIMIT);
  logic [W-1:0] cnt;

  assign hit = run & ~clr & tick & (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || !run)  cnt <= '0;
    else if (tick)         cnt <= hit ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl #(
  parameter int MAX_RETRY = 5,
  parameter int RETRY_MS  = 10000,
  parameter int CLEAR_MS  = 600000,
  parameter int BLANK_MS  = 20,
  parameter int HICCUP_MS = 1000,
  parameter int SYNC_STAGES = 2,
  localparam int CW = fr_pkg::cnt_bits(MAX_RETRY)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_ms,
  input  logic          in_ok,
  input  logic          on_n,
  input  logic          main_oc,
  input  logic          main_uv,
  input  logic          main_sense,
  input  logic          ov_flag,
  input  logic          sby_oc,
  output logic          main_en,
  output logic          sby_en,
  output logic          latched,
  output logic [CW-1:0] retry_cnt
);
  import fr_pkg::*;

  mstate_t       state;
  logic [CW-1:0] cnt;
  logic          ovl, hic;
  logic          on_lvl, on_fall, clear;
  logic          blank_trip, main_trip, wait_done, good_done, hic_done;
  logic          hic_start, ov_hit;

  fr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(on_n), .level(on_lvl), .fell(on_fall)
  );

  assign clear     = ~in_ok | on_fall;
  assign sby_en    = in_ok & ~hic & ~ovl;
  assign main_en   = sby_en & ~on_lvl & (state == M_RUN);
  assign main_trip = main_en & (main_uv | main_sense | blank_trip);
  assign hic_start = sby_en & sby_oc;
  assign ov_hit    = in_ok & ov_flag;
  assign latched   = ovl | (state == M_LATCH);
  assign retry_cnt = cnt;

  // Static overcurrent must outlast BLANK_MS whole ticks.
  fr_tick_timer #(.LIMIT(BLANK_MS + 1)) u_blank (
    .clk(clk), .rst_n(rst_n), .clr(clear), .run(main_en & main_oc),
    .tick(tick_ms), .hit(blank_trip)
  );

  fr_tick_timer #(.LIMIT(RETRY_MS)) u_wait (
    .clk(clk), .rst_n(rst_n), .clr(clear), .run(state == M_WAIT),
    .tick(tick_ms), .hit(wait_done)
  );

  fr_tick_timer #(.LIMIT(CLEAR_MS)) u_good (
    .clk(clk), .rst_n(rst_n), .clr(clear | main_trip), .run(main_en),
    .tick(tick_ms), .hit(good_done)
  );

  fr_tick_timer #(.LIMIT(HICCUP_MS)) u_hic (
    .clk(clk), .rst_n(rst_n), .clr(~in_ok), .run(hic),
    .tick(tick_ms), .hit(hic_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hic <= 1'b0;
      ovl <= 1'b0;
    end else begin
      if (!in_ok)         hic <= 1'b0;
      else if (hic_start) hic <= 1'b1;
      else if (hic_done)  hic <= 1'b0;
      if (clear)          ovl <= 1'b0;
      else if (ov_hit)    ovl <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= M_RUN;
      cnt   <= '0;
    end else if (clear) begin
      state <= M_RUN;
      cnt   <= '0;
    end else begin
      unique case (state)
        M_RUN: begin
          if (main_trip) begin
            if (attempts_used(int'(cnt), MAX_RETRY)) state <= M_LATCH;
            else begin
              state <= M_WAIT;
              cnt   <= cnt + CW'(1);
            end
          end else if (good_done) begin
            cnt <= '0;
          end
        end
        M_WAIT:  if (wait_done) state <= M_RUN;
        default: state <= M_LATCH;
      endcase
    end
  end

  p_fault_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (main_trip && !clear && cnt < CW'(MAX_RETRY)) |=> (retry_cnt == $past(retry_cnt) + CW'(1)) && !main_en);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cnt <= CW'(MAX_RETRY));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && !clear) |=> latched && !main_en);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ok |=> (retry_cnt == '0) && !latched);

  p_ov_kill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_hit && !clear) |=> latched && !main_en && !sby_en);

  p_hiccup_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hic_start && in_ok) |=> !sby_en && !main_en);
endmodule

// File: tb/fault_retry_ctrl_test.sv
`timescale 1ns/1ps
module fault_retry_ctrl_test;
  localparam int MAXR = 5, RETRY = 6, CLR = 40, BLANK = 3, HIC = 4;

  logic clk = 0, rst_n = 0, tick_ms = 0, in_ok = 0, on_n = 1;
  logic main_oc = 0, main_uv = 0, main_sense = 0, ov_flag = 0, sby_oc = 0;
  logic main_en, sby_en, latched;
  logic [2:0] retry_cnt;
  int tests = 0, fails = 0, cyc = 0, wd = 0;
  bit done = 0;

  fault_retry_ctrl #(.MAX_RETRY(MAXR), .RETRY_MS(RETRY), .CLEAR_MS(CLR),
    .BLANK_MS(BLANK), .HICCUP_MS(HIC)) uut (.*);

  always #2 clk = ~clk;

  // Reference model state
  int s1, s2, s3, mst, mcnt, wt, gt, bt, ht;
  bit mhic, movl;

  function automatic bit exp_sby();
    return in_ok && !mhic && !movl;
  endfunction
  function automatic bit exp_main();
    return exp_sby() && s2 == 0 && mst == 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 1; s2 = 1; s3 = 1; mst = 0; mcnt = 0; wt = 0; gt = 0; bt = 0; ht = 0;
      mhic = 0; movl = 0;
    end else begin
      bit fall, clr, em, es, btrip, trip, wdone, gdone, hdone, hstart;
      fall = (s3 == 1) && (s2 == 0);
      clr = !in_ok || fall;
      em = exp_main(); es = exp_sby();
      btrip = em && main_oc && !clr && tick_ms && bt == BLANK;
      trip = em && (main_uv || main_sense || btrip);
      wdone = mst == 1 && !clr && tick_ms && wt == RETRY - 1;
      gdone = em && !clr && !trip && tick_ms && gt == CLR - 1;
      hdone = mhic && in_ok && tick_ms && ht == HIC - 1;
      hstart = es && sby_oc;
      if (clr || !(em && main_oc)) bt = 0; else if (tick_ms) bt = btrip ? 0 : bt + 1;
      if (clr || mst != 1) wt = 0; else if (tick_ms) wt = wdone ? 0 : wt + 1;
      if (clr || trip || !em) gt = 0; else if (tick_ms) gt = gdone ? 0 : gt + 1;
      if (!in_ok || !mhic) ht = 0; else if (tick_ms) ht = hdone ? 0 : ht + 1;
      if (!in_ok) mhic = 0; else if (hstart) mhic = 1; else if (hdone) mhic = 0;
      if (clr) movl = 0; else if (in_ok && ov_flag) movl = 1;
      if (clr) begin mst = 0; mcnt = 0; end
      else if (mst == 0) begin
        if (trip) begin
          if (mcnt >= MAXR) mst = 2; else begin mst = 1; mcnt++; end
        end else if (gdone) mcnt = 0;
      end else if (mst == 1 && wdone) mst = 0;
      s3 = s2; s2 = s1; s1 = on_n;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Tick generator and per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    tick_ms = (cyc % 4 == 0);
    #1;
    if (rst_n && !done) begin
      check(main_en == exp_main(), "R2 main_en vs model", main_en, exp_main());
      check(sby_en == exp_sby(), "R9 sby_en vs model", sby_en, exp_sby());
      check(latched == (movl || mst == 2), "R4 latched vs model", latched, movl || mst == 2);
      check(retry_cnt == mcnt, "R3 retry_cnt vs model", retry_cnt, mcnt);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1; fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_main(output int n);
    n = 0;
    while (!main_en && n < 300) begin step(1); n++; end
  endtask

  task automatic pulse_uv();
    @(negedge clk); main_uv = 1;
    @(negedge clk); main_uv = 0; #1;
  endtask

  initial begin
    int n, r0, rises;
    bit prev;
    step(3); rst_n = 1; #1;
    check(main_en == 0, "R1 reset main_en", main_en, 0);
    check(sby_en == 0, "R1 reset sby_en", sby_en, 0);
    check(retry_cnt == 0, "R1 reset retry", retry_cnt, 0);
    check(latched == 0, "R1 reset latched", latched, 0);
    @(negedge clk); in_ok = 1; #1;
    check(sby_en == 1, "R1 sby follows in_ok", sby_en, 1);
    check(main_en == 0, "R10 main off while pin high", main_en, 0);
    @(negedge clk); on_n = 0;
    step(1); check(main_en == 0, "R10 one edge after pin low", main_en, 0);
    step(1); check(main_en == 1, "R10 two edges after pin low", main_en, 1);

    pulse_uv();
    check(main_en == 0, "R2 main off after fault", main_en, 0);
    check(sby_en == 1, "R2 standby kept", sby_en, 1);
    check(retry_cnt == 1, "R2 retry count", retry_cnt, 1);
    wait_main(n);
    check(main_en == 1, "R3 restart", main_en, 1);
    check(n >= (RETRY - 1) * 4, "R3 restart spacing", n, (RETRY - 1) * 4);

    for (int i = 0; i < MAXR - 1; i++) begin pulse_uv(); wait_main(n); end
    check(retry_cnt == MAXR, "R4 count at bound", retry_cnt, MAXR);
    @(negedge clk); main_sense = 1; @(negedge clk); main_sense = 0; #1;
    check(latched == 1, "R4 latch after last fault", latched, 1);
    check(retry_cnt == MAXR, "R4 count held", retry_cnt, MAXR);
    step(100);
    check(latched == 1 && main_en == 0, "R4 no restart", main_en, 0);
    check(sby_en == 1, "R4 standby alive", sby_en, 1);

    @(negedge clk); on_n = 1; step(3); on_n = 0; step(4);
    check(latched == 0, "R5 toggle clears latch", latched, 0);
    check(retry_cnt == 0, "R5 toggle clears count", retry_cnt, 0);
    check(main_en == 1, "R5 main back", main_en, 1);

    pulse_uv(); wait_main(n);
    check(retry_cnt == 1, "R6 count before good run", retry_cnt, 1);
    step(CLR * 4 + 20);
    check(retry_cnt == 0, "R6 count cleared by good run", retry_cnt, 0);

    r0 = retry_cnt;
    @(negedge clk); main_oc = 1; repeat (10) @(negedge clk); main_oc = 0; #1;
    check(main_en == 1, "R7 short overcurrent ignored", main_en, 1);
    check(retry_cnt == r0, "R7 short overcurrent no count", retry_cnt, r0);
    @(negedge clk); main_oc = 1; repeat (30) @(negedge clk); main_oc = 0; #1;
    check(main_en == 0, "R7 long overcurrent trips", main_en, 0);
    check(retry_cnt == r0 + 1, "R7 trip counted", retry_cnt, r0 + 1);
    wait_main(n);

    r0 = retry_cnt;
    @(negedge clk); sby_oc = 1; @(negedge clk); sby_oc = 0; #1;
    check(sby_en == 0 && main_en == 0, "R9 standby fault drops both", sby_en, 0);
    n = 0; while (!sby_en && n < 60) begin step(1); n++; end
    check(sby_en == 1, "R9 standby restarts", sby_en, 1);
    check(n >= (HIC - 1) * 4, "R9 off time", n, (HIC - 1) * 4);
    check(retry_cnt == r0, "R9 no main count", retry_cnt, r0);
    @(negedge clk); sby_oc = 1; rises = 0; prev = sby_en;
    for (int i = 0; i < 80; i++) begin
      step(1); if (sby_en && !prev) rises++; prev = sby_en;
    end
    sby_oc = 0;
    check(rises >= 2, "R9 repeated hiccup", rises, 2);
    wait_main(n);

    r0 = retry_cnt;
    @(negedge clk); ov_flag = 1; @(negedge clk); ov_flag = 0; #1;
    check(latched == 1, "R8 overvoltage latch", latched, 1);
    check(main_en == 0 && sby_en == 0, "R8 both off", sby_en, 0);
    check(retry_cnt == r0, "R8 count unchanged", retry_cnt, r0);
    step(60);
    check(latched == 1 && main_en == 0, "R8 no retry", main_en, 0);

    @(negedge clk); in_ok = 0; step(1);
    check(latched == 0, "R5 input loss clears latch", latched, 0);
    check(retry_cnt == 0, "R5 input loss clears count", retry_cnt, 0);
    step(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule